// File: doc/BRIEF.md
# Hardware Return Address Stack

This block keeps the return addresses for subroutine calls and interrupt entries of a processor core. A push request carries the current program counter; the pointer moves up by one first, and the value is then stored in the entry the pointer now selects. A pop request takes the address shown on the return output in that same cycle, and the pointer then moves down by one. Storage holds 2**PTR_W-1 words of PC_W bits. Pointer value 0 is the empty position and has no storage behind it.

Software reaches the block through a small byte-wide register port. It can read and write the pointer. It can read and write the selected entry one byte at a time: low, high and upper, where the upper byte holds only PC_W-16 bits. A separate flag register shows three states. Full means the pointer is at its maximum. Overflow and underflow are sticky: a push into a full stack sets overflow, and a pop from an empty stack sets underflow.

Top module: `ras_core`

## Requirements
- R1: After reset the pointer is 0, all storage is 0, overflow and underflow are 0, and ret_addr_o is 0.
- R2: full_o is 1 exactly when the pointer equals 31 (all ones). It is also readable as bit 0 of register address 4.
- R3: A push with the pointer below 31 increments the pointer and stores push_pc_i in the newly selected entry. ret_addr_o shows that value from the next cycle on.
- R4: ret_addr_o always shows the entry the pointer selects. A pop with a nonzero pointer decrements the pointer at the clock edge.
- R5: A push with the pointer at 31 sets the overflow flag and leaves the pointer and all entries unchanged.
- R6: A pop with the pointer at 0 sets the underflow flag, shows 0 on ret_addr_o and leaves the pointer at 0.
- R7: Register address 3 reads the pointer in bits 4:0, with bits 7:5 reading 0. A write there loads the pointer from wdata bits 4:0.
- R8: Register addresses 0, 1 and 2 read entry bits 7:0, 15:8 and 20:16, the last zero-extended. A write to one of them replaces only that slice of the selected entry.
- R9: While the pointer is 0, addresses 0 to 2 read 0 and writes to them change no entry.
- R10: Register address 4 shows full in bit 0, overflow in bit 1 and underflow in bit 2. Writing 0 to bit 1 or bit 2 clears that flag. Writing 1 has no effect, and only reset or such a write clears a flag.
- R11: When push and pop are requested together, the push is performed and the pop is ignored. A register write in a cycle that has a push or a pop is ignored.
- R12: Register addresses 5 to 7 read 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| push_i | input | 1 | Push request |
| push_pc_i | input | 21 | Address to save on a push |
| pop_i | input | 1 | Pop request |
| ret_addr_o | output | 21 | Entry selected by the pointer, 0 when the pointer is 0 |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for reg_addr_i, combinational |
| full_o | output | 1 | Pointer at maximum |
| ovf_o | output | 1 | Sticky overflow flag |
| unf_o | output | 1 | Sticky underflow flag |

## Verification
A pointer that drifts by one shows up on ret_addr_o in the very next cycle, because the output always presents the entry the pointer selects and the reference model predicts that value every cycle. A corrupted entry stays hidden until the pointer reaches it again. For that reason the bench walks the pointer back over stored entries by pops and by pointer writes, and reads every byte. Flag errors are visible at once on the flag outputs. Byte-merge errors are visible on the first read of the written entry.

// File: rtl/ras_pkg.sv
package ras_pkg;

  // register map of the byte-wide software port
  typedef enum logic [2:0] {
    RA_TOS_LO = 3'd0,
    RA_TOS_HI = 3'd1,
    RA_TOS_UP = 3'd2,
    RA_PTR    = 3'd3,
    RA_FLAGS  = 3'd4
  } ras_reg_e;

  // bit positions inside the flag register
  localparam int FLG_FULL = 0;
  localparam int FLG_OVF  = 1;
  localparam int FLG_UNF  = 2;

  // qualified stack events, brought out for checking
  typedef struct packed {
    logic push_ok;
    logic push_ovf;
    logic pop_ok;
    logic pop_unf;
  } ras_evt_t;

endpackage

// File: rtl/ras_ptr.sv
module ras_ptr
  import ras_pkg::*;
#(
  parameter int PTR_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic             ptr_wr_i,
  input  logic [PTR_W-1:0] ptr_wdata_i,
  input  logic             ovf_clr_i,
  input  logic             unf_clr_i,
  output logic [PTR_W-1:0] ptr_o,
  output logic             full_o,
  output logic             ovf_o,
  output logic             unf_o,
  output ras_evt_t         evt_o
);

  localparam logic [PTR_W-1:0] PTR_MAX  = {PTR_W{1'b1}};
  localparam logic [PTR_W-1:0] PTR_ZERO = '0;

  logic [PTR_W-1:0] ptr_q;
  logic             ovf_q, unf_q;
  logic             at_max, at_zero;

  function automatic logic [PTR_W-1:0] step_up(input logic [PTR_W-1:0] p);
    return p + PTR_W'(1);
  endfunction

  function automatic logic [PTR_W-1:0] step_down(input logic [PTR_W-1:0] p);
    return p - PTR_W'(1);
  endfunction

  assign at_max  = (ptr_q == PTR_MAX);
  assign at_zero = (ptr_q == PTR_ZERO);

  // push has priority; a pop in the same cycle is dropped
  always_comb begin
    evt_o.push_ok  = push_i & ~at_max;
    evt_o.push_ovf = push_i &  at_max;
    evt_o.pop_ok   = pop_i & ~push_i & ~at_zero;
    evt_o.pop_unf  = pop_i & ~push_i &  at_zero;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= PTR_ZERO;
    end else if (evt_o.push_ok) begin
      ptr_q <= step_up(ptr_q);
    end else if (evt_o.pop_ok) begin
      ptr_q <= step_down(ptr_q);
    end else if (ptr_wr_i) begin
      ptr_q <= ptr_wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else begin
      if (evt_o.push_ovf)   ovf_q <= 1'b1;
      else if (ovf_clr_i)   ovf_q <= 1'b0;
      if (evt_o.pop_unf)    unf_q <= 1'b1;
      else if (unf_clr_i)   unf_q <= 1'b0;
    end
  end

  assign ptr_o  = ptr_q;
  assign full_o = at_max;
  assign ovf_o  = ovf_q;
  assign unf_o  = unf_q;

  AST_PUSH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    evt_o.push_ok |=> ptr_o == $past(ptr_o) + PTR_W'(1)); // R3
  AST_POP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    evt_o.pop_ok |=> ptr_o == $past(ptr_o) - PTR_W'(1)); // R4
  AST_OVF_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    evt_o.push_ovf |=> ovf_o && $stable(ptr_o)); // R5
  AST_UNF_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    evt_o.pop_unf |=> unf_o && ptr_o == PTR_ZERO); // R6
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o && !ovf_clr_i |=> ovf_o); // R10
  AST_UNF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    unf_o && !unf_clr_i |=> unf_o); // R10
  AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({evt_o.push_ok, evt_o.push_ovf, evt_o.pop_ok, evt_o.pop_unf})); // R11

endmodule

// File: rtl/ras_mem.sv
module ras_mem #(
  parameter int PC_W  = 21,
  parameter int PTR_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_i,
  input  logic [PTR_W-1:0] wslot_i,
  input  logic [PC_W-1:0]  wdata_i,
  input  logic [PTR_W-1:0] rslot_i,
  output logic [PC_W-1:0]  rdata_o
);

  localparam int DEPTH = (1 << PTR_W) - 1;

  logic [PC_W-1:0] ent_q [DEPTH];

  // one register per entry, each with its own write select
  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic sel;
    assign sel = we_i && (wslot_i == PTR_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   ent_q[g] <= '0;
      else if (sel) ent_q[g] <= wdata_i;
    end
  end

  // read slot beyond the last entry returns zero
  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (rslot_i == PTR_W'(i)) rdata_o = ent_q[i];
    end
  end

endmodule

// File: rtl/ras_regs.sv
module ras_regs
  import ras_pkg::*;
#(
  parameter int PC_W  = 21,
  parameter int PTR_W = 5
) (
  input  logic             reg_wr_i,
  input  logic [2:0]       reg_addr_i,
  input  logic [7:0]       reg_wdata_i,
  input  logic             busy_i,
  input  logic [PTR_W-1:0] ptr_i,
  input  logic [PC_W-1:0]  top_i,
  input  logic             full_i,
  input  logic             ovf_i,
  input  logic             unf_i,
  output logic [7:0]       reg_rdata_o,
  output logic             ptr_wr_o,
  output logic [PTR_W-1:0] ptr_wdata_o,
  output logic             tos_wr_o,
  output logic [PC_W-1:0]  tos_wdata_o,
  output logic             ovf_clr_o,
  output logic             unf_clr_o
);

  localparam int UP_W = PC_W - 16;

  logic wr_ok;
  logic have_top;
  logic addr_tos;

  // replace one byte-slice of the selected entry
  function automatic logic [PC_W-1:0] put_slice(input logic [PC_W-1:0] w,
                                                input logic [2:0] a,
                                                input logic [7:0] b);
    logic [PC_W-1:0] r;
    r = w;
    case (a)
      RA_TOS_LO: r[7:0]       = b;
      RA_TOS_HI: r[15:8]      = b;
      RA_TOS_UP: r[PC_W-1:16] = b[UP_W-1:0];
      default:   r = w;
    endcase
    return r;
  endfunction

  assign wr_ok    = reg_wr_i & ~busy_i;
  assign have_top = (ptr_i != '0);
  assign addr_tos = (reg_addr_i == RA_TOS_LO) || (reg_addr_i == RA_TOS_HI)
                    || (reg_addr_i == RA_TOS_UP);

  assign ptr_wr_o    = wr_ok && (reg_addr_i == RA_PTR);
  assign ptr_wdata_o = reg_wdata_i[PTR_W-1:0];
  assign tos_wr_o    = wr_ok && addr_tos && have_top;
  assign tos_wdata_o = put_slice(top_i, reg_addr_i, reg_wdata_i);
  assign ovf_clr_o   = wr_ok && (reg_addr_i == RA_FLAGS) && !reg_wdata_i[FLG_OVF];
  assign unf_clr_o   = wr_ok && (reg_addr_i == RA_FLAGS) && !reg_wdata_i[FLG_UNF];

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      RA_TOS_LO: reg_rdata_o = top_i[7:0];
      RA_TOS_HI: reg_rdata_o = top_i[15:8];
      RA_TOS_UP: reg_rdata_o = 8'(top_i[PC_W-1:16]);
      RA_PTR:    reg_rdata_o = 8'(ptr_i);
      RA_FLAGS: begin
        reg_rdata_o[FLG_FULL] = full_i;
        reg_rdata_o[FLG_OVF]  = ovf_i;
        reg_rdata_o[FLG_UNF]  = unf_i;
      end
      default:   reg_rdata_o = '0;
    endcase
  end

  always_comb begin
    if (!have_top) AST_EMPTY_READ: assert (top_i == '0); // R9
  end

endmodule

// File: rtl/ras_core.sv
module ras_core
  import ras_pkg::*;
#(
  parameter int PC_W  = 21,
  parameter int PTR_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  logic [PC_W-1:0]  push_pc_i,
  input  logic             pop_i,
  output logic [PC_W-1:0]  ret_addr_o,
  input  logic             reg_wr_i,
  input  logic [2:0]       reg_addr_i,
  input  logic [7:0]       reg_wdata_i,
  output logic [7:0]       reg_rdata_o,
  output logic             full_o,
  output logic             ovf_o,
  output logic             unf_o
);

  ras_evt_t         evt;
  logic [PTR_W-1:0] ptr;
  logic             busy;
  logic             ptr_wr, tos_wr, ovf_clr, unf_clr;
  logic [PTR_W-1:0] ptr_wdata;
  logic [PC_W-1:0]  tos_wdata;
  logic             mem_we;
  logic [PTR_W-1:0] mem_wslot, mem_rslot;
  logic [PC_W-1:0]  mem_wdata, mem_rdata;
  logic [PC_W-1:0]  top_val;

  // pointer p (1..max) lives in storage slot p-1
  function automatic logic [PTR_W-1:0] slot_of(input logic [PTR_W-1:0] p);
    return p - PTR_W'(1);
  endfunction

  assign busy = push_i | pop_i;

  ras_ptr #(.PTR_W(PTR_W)) u_ptr (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_i     (push_i),
    .pop_i      (pop_i),
    .ptr_wr_i   (ptr_wr),
    .ptr_wdata_i(ptr_wdata),
    .ovf_clr_i  (ovf_clr),
    .unf_clr_i  (unf_clr),
    .ptr_o      (ptr),
    .full_o     (full_o),
    .ovf_o      (ovf_o),
    .unf_o      (unf_o),
    .evt_o      (evt)
  );

  // push lands one above the current pointer, i.e. in slot ptr
  assign mem_we    = evt.push_ok | tos_wr;
  assign mem_wslot = evt.push_ok ? ptr : slot_of(ptr);
  assign mem_wdata = evt.push_ok ? push_pc_i : tos_wdata;
  assign mem_rslot = slot_of(ptr);

  ras_mem #(.PC_W(PC_W), .PTR_W(PTR_W)) u_mem (
    .clk    (clk),
    .rst_n  (rst_n),
    .we_i   (mem_we),
    .wslot_i(mem_wslot),
    .wdata_i(mem_wdata),
    .rslot_i(mem_rslot),
    .rdata_o(mem_rdata)
  );

  assign top_val    = (ptr == '0) ? '0 : mem_rdata;
  assign ret_addr_o = top_val;

  ras_regs #(.PC_W(PC_W), .PTR_W(PTR_W)) u_regs (
    .reg_wr_i   (reg_wr_i),
    .reg_addr_i (reg_addr_i),
    .reg_wdata_i(reg_wdata_i),
    .busy_i     (busy),
    .ptr_i      (ptr),
    .top_i      (top_val),
    .full_i     (full_o),
    .ovf_i      (ovf_o),
    .unf_i      (unf_o),
    .reg_rdata_o(reg_rdata_o),
    .ptr_wr_o   (ptr_wr),
    .ptr_wdata_o(ptr_wdata),
    .tos_wr_o   (tos_wr),
    .tos_wdata_o(tos_wdata),
    .ovf_clr_o  (ovf_clr),
    .unf_clr_o  (unf_clr)
  );

  AST_PUSH_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    evt.push_ok |=> ret_addr_o == $past(push_pc_i)); // R3
  AST_OVF_KEEPS_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    evt.push_ovf |=> $stable(ret_addr_o)); // R5
  AST_UNF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    evt.pop_unf |-> ret_addr_o == '0); // R6
  AST_BUSY_NO_REG: assert property (@(posedge clk) disable iff (!rst_n)
    busy && reg_wr_i && !evt.push_ok |=> $stable(ret_addr_o) || $past(evt.pop_ok)); // R11

endmodule

// File: tb/ras_core_test.sv
module ras_core_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        push_i = 1'b0;
  logic [20:0] push_pc_i = '0;
  logic        pop_i = 1'b0;
  logic [20:0] ret_addr_o;
  logic        reg_wr_i = 1'b0;
  logic [2:0]  reg_addr_i = '0;
  logic [7:0]  reg_wdata_i = '0;
  logic [7:0]  reg_rdata_o;
  logic        full_o, ovf_o, unf_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // behavioural reference state
  logic [20:0] m_ent [32];
  int          m_ptr;
  bit          m_ovf, m_unf;

  always #5 clk = ~clk;

  ras_core uut (
    .clk(clk), .rst_n(rst_n),
    .push_i(push_i), .push_pc_i(push_pc_i), .pop_i(pop_i),
    .ret_addr_o(ret_addr_o),
    .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o),
    .full_o(full_o), .ovf_o(ovf_o), .unf_o(unf_o)
  );

  function automatic logic [20:0] m_top();
    return (m_ptr == 0) ? 21'd0 : m_ent[m_ptr];
  endfunction

  function automatic logic [7:0] m_read(input logic [2:0] a);
    logic [20:0] t;
    t = m_top();
    case (a)
      3'd0: return t[7:0];
      3'd1: return t[15:8];
      3'd2: return {3'b000, t[20:16]};
      3'd3: return 8'(m_ptr);
      3'd4: return {5'b0, m_unf, m_ovf, (m_ptr == 31)};
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // one clock: drive, compare against model, advance model
  task automatic step(input string tag, input bit ps, input logic [20:0] pc, input bit pp,
                      input bit wr, input logic [2:0] a, input logic [7:0] wd);
    push_i = ps; push_pc_i = pc; pop_i = pp;
    reg_wr_i = wr; reg_addr_i = a; reg_wdata_i = wd;
    #1;
    check(tag, "ret_addr", int'(ret_addr_o), int'(m_top()));
    check(tag, "rdata", int'(reg_rdata_o), int'(m_read(a)));
    check(tag, "flags", int'({full_o, ovf_o, unf_o}),
          int'({(m_ptr == 31), m_ovf, m_unf}));
    @(posedge clk);
    if (ps) begin
      if (m_ptr == 31) m_ovf = 1;
      else begin m_ptr++; m_ent[m_ptr] = pc; end
    end else if (pp) begin
      if (m_ptr == 0) m_unf = 1;
      else m_ptr--;
    end else if (wr) begin
      case (a)
        3'd0: if (m_ptr != 0) m_ent[m_ptr][7:0] = wd;
        3'd1: if (m_ptr != 0) m_ent[m_ptr][15:8] = wd;
        3'd2: if (m_ptr != 0) m_ent[m_ptr][20:16] = wd[4:0];
        3'd3: m_ptr = int'(wd[4:0]);
        3'd4: begin
          if (!wd[1]) m_ovf = 0;
          if (!wd[2]) m_unf = 0;
        end
        default: ;
      endcase
    end
    @(negedge clk);
    push_i = 0; pop_i = 0; reg_wr_i = 0;
  endtask

  task automatic rd(input string tag, input logic [2:0] a);
    step(tag, 0, '0, 0, 0, a, 8'h00);
  endtask

  task automatic wr(input string tag, input logic [2:0] a, input logic [7:0] d);
    step(tag, 0, '0, 0, 1, a, d);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) m_ent[i] = '0;
    m_ptr = 0; m_ovf = 0; m_unf = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd("R1", 3'd4);
    rd("R1", 3'd3);
    rd("R1", 3'd0);

    // R3 pushes
    step("R3", 1, 21'h1A2B3C, 0, 0, 3'd3, 0);
    step("R3", 1, 21'h000D58, 0, 0, 3'd0, 0);
    step("R3", 1, 21'h1FFFFE, 0, 0, 3'd1, 0);
    rd("R8", 3'd0); rd("R8", 3'd1); rd("R8", 3'd2);
    rd("R7", 3'd3);

    // R4 pop shows top then moves down
    step("R4", 0, '0, 1, 0, 3'd3, 0);
    rd("R4", 3'd3);

    // R11 push wins over pop; register write during busy ignored
    step("R11", 1, 21'h012345, 1, 0, 3'd3, 0);
    rd("R11", 3'd3);
    step("R11", 1, 21'h054321, 0, 1, 3'd3, 8'h07);
    rd("R11", 3'd3);
    step("R11", 0, '0, 1, 1, 3'd0, 8'hAA);
    rd("R11", 3'd0);

    // R7 pointer write
    wr("R7", 3'd3, 8'hE2);
    rd("R7", 3'd3); rd("R7", 3'd1);

    // R8 byte-slice writes
    wr("R8", 3'd0, 8'h5A);
    rd("R8", 3'd0); rd("R8", 3'd1);
    wr("R8", 3'd2, 8'hFF);
    rd("R8", 3'd2);
    wr("R8", 3'd1, 8'hC3);
    rd("R8", 3'd1); rd("R8", 3'd0);

    // R6 pop down to empty and below
    step("R4", 0, '0, 1, 0, 3'd3, 0);
    step("R4", 0, '0, 1, 0, 3'd3, 0);
    step("R6", 0, '0, 1, 0, 3'd4, 0);
    rd("R6", 3'd4); rd("R6", 3'd3);
    step("R6", 0, '0, 1, 0, 3'd0, 0);

    // R10 flag clears
    wr("R10", 3'd4, 8'hFF);
    rd("R10", 3'd4);
    wr("R10", 3'd4, 8'h00);
    rd("R10", 3'd4);

    // R9 writes at pointer 0 ignored
    wr("R9", 3'd0, 8'h77); wr("R9", 3'd2, 8'h1F);
    rd("R9", 3'd0); rd("R9", 3'd2);
    wr("R9", 3'd3, 8'h01);
    rd("R9", 3'd0); rd("R9", 3'd2);

    // R2 and R5 full and overflow
    wr("R2", 3'd3, 8'h1E);
    rd("R2", 3'd4);
    step("R2", 1, 21'h0ABCDE, 0, 0, 3'd4, 0);
    rd("R2", 3'd4);
    step("R5", 1, 21'h111111, 0, 0, 3'd3, 0);
    rd("R5", 3'd3); rd("R5", 3'd0); rd("R5", 3'd4);
    wr("R10", 3'd4, 8'h04);
    rd("R10", 3'd4);
    step("R5", 0, '0, 1, 0, 3'd4, 0);
    rd("R5", 3'd0);

    // R12 unmapped addresses
    wr("R12", 3'd5, 8'hFF); wr("R12", 3'd7, 8'h00);
    rd("R12", 3'd5); rd("R12", 3'd6); rd("R12", 3'd7); rd("R12", 3'd3);

    done = 1;
    summary();
    $finish;
  end

endmodule